// File: doc/BRIEF.md
# Dual-Ratio Lockstep Clock Divider

This block takes one input clock and produces two divided clocks. Bank A divides by 2 or 4 and bank B divides by 4 or 6, with one select input per bank. Both banks are driven by a single shared phase counter that wraps every 12 input cycles, the least common multiple of all the ratios. Rising edges that the two outputs have in common therefore always fall on the same input clock edge. Every output is a registered signal in the input clock domain.

The enable is captured on the falling edge of the input clock. A change in the enable, or in either select, takes effect only at a frame boundary. At that point every output is low, so no output ever produces a shortened pulse. An asynchronous, active-high master reset clears all state. Several instances that are released from reset together stay in phase with one another. Within one instance the two outputs cannot drift apart, because they are decoded from the same counter.

Top module: `lockstep_clk_divider`

## Requirements
- R1: With `sel_a_i`=0, `clk_a_o` divides by 2; with `sel_a_i`=1, it divides by 4. Each period is high for its first half and low for its second half (50% duty cycle).
- R2: With `sel_b_i`=0, `clk_b_o` divides by 4; with `sel_b_i`=1, it divides by 6 (high 3 cycles, low 3 cycles). The duty cycle is 50%, high first.
- R3: Each 12-cycle frame starts with both outputs rising on the same input clock edge. Every frame position is decoded from one shared counter.
- R4: `en_i` is sampled on the falling input edge. When the divider is idle and that sample is 1, both outputs go high on the next rising edge.
- R5: When the falling-edge sample of `en_i` is 0, the current frame completes first. Both outputs are then held low until the divider is enabled again.
- R6: A select value is taken only at the start of a frame. A change in the middle of a frame leaves the running frame unchanged.
- R7: While `mrst_i`=1, both outputs are low at once, without waiting for a clock edge. After release, the outputs start as described in R4.
- R8: Under random toggling of the enable and the selects, every high pulse on `clk_a_o` lasts 1 or 2 input cycles. Every high pulse on `clk_b_o` lasts 2 or 3 input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| mrst_i | input | 1 | Asynchronous master reset, active high |
| en_i | input | 1 | Enable, sampled on the falling edge of `clk_i` |
| sel_a_i | input | 1 | Bank A ratio: 0 selects /2, 1 selects /4 |
| sel_b_i | input | 1 | Bank B ratio: 0 selects /4, 1 selects /6 |
| clk_a_o | output | 1 | Bank A divided clock |
| clk_b_o | output | 1 | Bank B divided clock |

## Verification
A wrong count in the shared phase counter shows within one frame, at most 12 input cycles. It appears as a missing or displaced joint rising edge, or as a pulse whose length is not half its ratio. A wrong run flag or a wrong latched select shows on the next rising edge after the frame boundary. The output then rises while it should stay idle, stays low while it should start, or switches to the wrong period. The bench compares every output sample against the expected waveform, so a single wrong cycle on either bank is reported.

// File: rtl/lckdiv_pkg.sv
package lckdiv_pkg;

    function automatic int gcd_f(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int lcm_f(input int a, input int b);
        return (a / gcd_f(a, b)) * b;
    endfunction

endpackage

// File: rtl/lckdiv_en_capture.sv
// Enable capture flop, clocked on the falling edge of the input clock.
module lckdiv_en_capture (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic en_q_o
);
    logic en_d;
    logic en_q;

    always_comb begin
        en_d = en_i;
    end

    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) en_q <= 1'b0;
        else       en_q <= en_d;
    end

    assign en_q_o = en_q;
endmodule

// File: rtl/lckdiv_phase_ctrl.sv
// Shared frame counter, run flag and per-frame select latches.
module lckdiv_phase_ctrl #(
    parameter int FRAME = 12,
    parameter int CW    = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_q_i,
    input  logic          sel_a_i,
    input  logic          sel_b_i,
    output logic          run_d_o,
    output logic [CW-1:0] cnt_d_o,
    output logic          sa_d_o,
    output logic          sb_d_o,
    output logic          run_q_o,
    output logic [CW-1:0] cnt_q_o,
    output logic          sa_q_o
);
    localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          sa;
        logic          sb;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        // A count at or past LAST (including an unreachable power-up value) wraps to the frame start.
        if (!st_q.run || (st_q.cnt >= LAST)) begin
            st_d.cnt = '0;
            st_d.run = en_q_i;
            if (en_q_i) begin
                st_d.sa = sel_a_i;
                st_d.sb = sel_b_i;
            end
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign run_d_o = st_d.run;
    assign cnt_d_o = st_d.cnt;
    assign sa_d_o  = st_d.sa;
    assign sb_d_o  = st_d.sb;
    assign run_q_o = st_q.run;
    assign cnt_q_o = st_q.cnt;
    assign sa_q_o  = st_q.sa;
endmodule

// File: rtl/lckdiv_wave_bank.sv
// One output bank: decodes the next frame position into a registered 50% clock.
module lckdiv_wave_bank #(
    parameter int LO = 2,
    parameter int HI = 4,
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_d_i,
    input  logic [CW-1:0] cnt_d_i,
    input  logic          sel_d_i,
    output logic          clk_o
);
    logic lo_hi_half;
    logic hi_hi_half;
    logic out_d;
    logic out_q;

    always_comb begin
        lo_hi_half = (int'(cnt_d_i) % LO) < (LO / 2);
        hi_hi_half = (int'(cnt_d_i) % HI) < (HI / 2);
        out_d      = run_d_i && (sel_d_i ? hi_hi_half : lo_hi_half);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) out_q <= 1'b0;
        else       out_q <= out_d;
    end

    assign clk_o = out_q;
endmodule

// File: rtl/lockstep_clk_divider.sv
module lockstep_clk_divider #(
    parameter int A_LO = 2,
    parameter int A_HI = 4,
    parameter int B_LO = 4,
    parameter int B_HI = 6
) (
    input  logic clk_i,
    input  logic mrst_i,
    input  logic en_i,
    input  logic sel_a_i,
    input  logic sel_b_i,
    output logic clk_a_o,
    output logic clk_b_o
);
    import lckdiv_pkg::*;

    localparam int FRAME = lcm_f(lcm_f(lcm_f(A_LO, A_HI), B_LO), B_HI);
    localparam int CW    = (FRAME > 1) ? $clog2(FRAME) : 1;

    logic          en_q;
    logic          run_d;
    logic [CW-1:0] cnt_d;
    logic          sa_d;
    logic          sb_d;
    logic          run_q;
    logic [CW-1:0] cnt_q;
    logic          sel_a_q;

    lckdiv_en_capture u_en (
        .clk_i  (clk_i),
        .rst_i  (mrst_i),
        .en_i   (en_i),
        .en_q_o (en_q)
    );

    lckdiv_phase_ctrl #(.FRAME(FRAME), .CW(CW)) u_phase (
        .clk_i   (clk_i),
        .rst_i   (mrst_i),
        .en_q_i  (en_q),
        .sel_a_i (sel_a_i),
        .sel_b_i (sel_b_i),
        .run_d_o (run_d),
        .cnt_d_o (cnt_d),
        .sa_d_o  (sa_d),
        .sb_d_o  (sb_d),
        .run_q_o (run_q),
        .cnt_q_o (cnt_q),
        .sa_q_o  (sel_a_q)
    );

    lckdiv_wave_bank #(.LO(A_LO), .HI(A_HI), .CW(CW)) u_bank_a (
        .clk_i   (clk_i),
        .rst_i   (mrst_i),
        .run_d_i (run_d),
        .cnt_d_i (cnt_d),
        .sel_d_i (sa_d),
        .clk_o   (clk_a_o)
    );

    lckdiv_wave_bank #(.LO(B_LO), .HI(B_HI), .CW(CW)) u_bank_b (
        .clk_i   (clk_i),
        .rst_i   (mrst_i),
        .run_d_i (run_d),
        .cnt_d_i (cnt_d),
        .sel_d_i (sb_d),
        .clk_o   (clk_b_o)
    );
endmodule

// File: rtl/lckdiv_checker.sv
module lckdiv_checker #(
    parameter int FRAME = 12,
    parameter int CW    = 4
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          run_q,
    input logic [CW-1:0] cnt_q,
    input logic          sel_a_q,
    input logic          clk_a_o,
    input logic          clk_b_o
);
    localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

    p_rst_low_r7: assert property (@(posedge clk_i)
        rst_i |-> (!clk_a_o && !clk_b_o));

    p_frame_rise_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && cnt_q == '0) |-> (clk_a_o && clk_b_o));

    p_start_high_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(run_q) |-> (clk_a_o && clk_b_o));

    p_stop_at_end_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(run_q) |-> ($past(cnt_q) == LAST));

    p_idle_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_q |-> (!clk_a_o && !clk_b_o));

    p_sel_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && cnt_q != '0) |-> $stable(sel_a_q));

    p_half_rate_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && $past(run_q) && !sel_a_q) |-> (clk_a_o != $past(clk_a_o)));
endmodule

bind lockstep_clk_divider lckdiv_checker #(.FRAME(FRAME), .CW(CW)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (mrst_i),
    .run_q   (run_q),
    .cnt_q   (cnt_q),
    .sel_a_q (sel_a_q),
    .clk_a_o (clk_a_o),
    .clk_b_o (clk_b_o)
);

// File: tb/lockstep_clk_divider_tb_top.sv
`timescale 1ns/100ps
module lockstep_clk_divider_tb_top;

    localparam int FR = 12;

    logic clk     = 1'b0;
    logic mrst_i  = 1'b1;
    logic en_i    = 1'b0;
    logic sel_a_i = 1'b0;
    logic sel_b_i = 1'b0;
    logic clk_a_o;
    logic clk_b_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    typedef struct {
        int    cyc;
        bit    a;
        bit    b;
        string tag_a;
        string tag_b;
    } exp_t;
    exp_t sb_q[$];

    // Expected-waveform state, derived from the requirements.
    bit brun = 0;
    int bpos = 0;
    int bra  = 2;
    int brb  = 4;

    lockstep_clk_divider dut_i (
        .clk_i   (clk),
        .mrst_i  (mrst_i),
        .en_i    (en_i),
        .sel_a_i (sel_a_i),
        .sel_b_i (sel_b_i),
        .clk_a_o (clk_a_o),
        .clk_b_o (clk_b_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
        end
    endtask

    // Driver: drives one cycle of stimulus and pushes the expected sample of the next cycle.
    task automatic step(input bit en, input bit sa, input bit sb, input bit rst);
        bit    prev_run;
        int    pra;
        int    prb;
        exp_t  e;
        @(posedge clk);
        #2;
        en_i    = en;
        sel_a_i = sa;
        sel_b_i = sb;
        mrst_i  = rst;
        prev_run = brun;
        pra = bra;
        prb = brb;
        if (rst) begin
            brun = 0;
            bpos = 0;
            #0.3;
            check("R7", clk_a_o, 0);
            check("R7", clk_b_o, 0);
        end else if (!brun || bpos == FR - 1) begin
            bpos = 0;
            brun = en;
            if (en) begin
                bra = sa ? 4 : 2;
                brb = sb ? 6 : 4;
            end
        end else begin
            bpos++;
        end
        e.cyc   = cyc + 1;
        e.a     = brun && ((bpos % bra) < bra / 2);
        e.b     = brun && ((bpos % brb) < brb / 2);
        e.tag_a = "R1";
        e.tag_b = "R2";
        if (rst) begin
            e.tag_a = "R7"; e.tag_b = "R7";
        end else if (!prev_run && brun) begin
            e.tag_a = "R4"; e.tag_b = "R4";
        end else if (prev_run && !brun) begin
            e.tag_a = "R5"; e.tag_b = "R5";
        end else if (brun && bpos == 0 && (pra != bra || prb != brb)) begin
            e.tag_a = "R6"; e.tag_b = "R6";
        end else if (brun && bpos == 0) begin
            e.tag_a = "R3"; e.tag_b = "R3";
        end
        sb_q.push_back(e);
    endtask

    // Monitor: pops expected samples and compares them with the outputs.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.cyc == cyc) begin
                    check(e.tag_a, clk_a_o, e.a);
                    check(e.tag_b, clk_b_o, e.b);
                end
            end
        end
    end

    // Pulse-width monitor (R8).
    int a_len = 0;
    int b_len = 0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mrst_i) begin
                a_len = 0;
                b_len = 0;
            end else begin
                if (clk_a_o) a_len++;
                else if (a_len > 0) begin
                    check("R8", int'(a_len == 1 || a_len == 2), 1);
                    a_len = 0;
                end
                if (clk_b_o) b_len++;
                else if (b_len > 0) begin
                    check("R8", int'(b_len == 2 || b_len == 3), 1);
                    b_len = 0;
                end
            end
        end
    end

    function automatic void summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
        check("R7", clk_a_o, 0);
        check("R7", clk_b_o, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
        // All four select combinations; changes land mid-frame.
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 30; i++) step(1, c[0], c[1], 0);
        // Disable in the middle of a frame.
        for (int i = 0; i < 20; i++) step(0, 1, 1, 0);
        for (int i = 0; i < 26; i++) step(1, 1, 0, 0);
        // Random enable and select toggling.
        for (int i = 0; i < 500; i++)
            step(($urandom % 3) != 0, $urandom % 2, $urandom % 2, 0);
        // Reset while running, then release with the enable high.
        for (int i = 0; i < 17; i++) step(1, 0, 1, 0);
        for (int i = 0; i < 2; i++) step(1, 0, 1, 1);
        for (int i = 0; i < 30; i++) step(1, 1, 1, 0);
        for (int i = 0; i < 14; i++) step(0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        summary();
        $finish;
    end

endmodule